// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management register file of a single Ethernet PHY. A host register bank drives it through three write strobes. An address word names the target PHY and register. A data word starts a write. A command word starts a read, and the read result is captured into a read-result register that the host can sample. Serial pin timing, extended (clause-45) addressing and real autonegotiation are not modelled. Autonegotiation completes at once when it is requested.

The register file holds the usual PHY registers with fixed reset values. Writes to the control register have side effects: a soft reset reloads every register, and an autonegotiation request marks autonegotiation as complete. Both request bits clear themselves. An external link input is mirrored into the link and autonegotiation-complete bits of the status register. This happens whenever the input changes and after every reset.

Top module: `phy_mgmt_responder`

## Requirements
- R1: On `addr_we` the block latches `addr_word`. Bits 4:0 select the register (0 = control, 1 = status, 2 and 3 = identifier, 4 = advertisement, 5 = partner ability). Bits 12:8 select the PHY. Every later access uses the latched word.
- R2: After hardware reset the registers read control 0x1140, identifier 0x0022 / 0x1550, advertisement 0x01E1 and partner ability 0xCDE1. Status reads 0x7968 with bits 2 and 5 then set by the link rule (R9). Every other register reads 0.
- R3: A read command while the latched PHY address is not 1 captures 0xFFFF.
- R4: A data write while the latched PHY address is not 1 changes no register.
- R5: A pulse on `data_we` stores `data_word[15:0]` into the addressed register. A pulse on `cmd_we` with `cmd_word[0]`=1 captures the addressed register into `rd_data` one clock later. A command with bit 0 clear leaves `rd_data` unchanged.
- R6: `done` is high for exactly the one cycle that follows each data write and each read command (bit 0 set), ignored or not. Otherwise it is low.
- R7: A write to the control register with bit 15 set first reloads every register with its reset value and applies the link rule. It then stores the written value with bit 15 cleared.
- R8: A write to the control register with bit 12 set stores the value with bit 12 cleared and sets bit 5 of the status register.
- R9: Status bits 2 (link) and 5 (autonegotiation complete) are both set while `link_up` is 1 and both cleared while it is 0. The rule is applied on every change of `link_up`, on the first cycle after hardware reset, and on every soft reset. With link up, status reads 0x796C after reset. With link down it reads 0x7948.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Strobe that latches the address word |
| addr_word | input | 16 | PHY address in bits 12:8, register number in bits 4:0 |
| data_we | input | 1 | Strobe that starts a register write |
| data_word | input | 32 | Write data; only bits 15:0 are used |
| cmd_we | input | 1 | Strobe for the command word |
| cmd_word | input | 8 | Bit 0 requests a read |
| link_up | input | 1 | Link state seen by the PHY, synchronous to clk |
| rd_data | output | 16 | Captured read result |
| done | output | 1 | One-cycle pulse after each access |

## Verification
Some rules are checked by assertions on every cycle. The `done` pulse must follow each access and appear at no other time. A read to a foreign PHY must yield 0xFFFF. A matching read must return, one clock later, the word the register file offered. `rd_data` must hold steady when no read is requested. The register contents themselves can only be shown by the bench scenarios, which compare them against a bench-side model. These scenarios cover the reset values, soft reset reload, the self-clearing control bits, ignored foreign writes, link toggles and a second hardware reset taken with the link down.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_W      = 16;
    localparam int REG_IDX_W  = 5;
    localparam int NUM_REGS   = 1 << REG_IDX_W;
    localparam int PHY_IDX_W  = 5;
    localparam int PHY_LSB    = 8;

    localparam logic [REG_IDX_W-1:0] IDX_CTRL = 5'd0;
    localparam logic [REG_IDX_W-1:0] IDX_STAT = 5'd1;

    localparam int CTRL_SOFT_RST = 15;
    localparam int CTRL_AN_REQ   = 12;
    localparam int STAT_LINK     = 2;
    localparam int STAT_AN_DONE  = 5;

    function automatic logic [REG_W-1:0] power_on_value(input logic [REG_IDX_W-1:0] idx);
        case (idx)
            5'd0:    return 16'h1140;
            5'd1:    return 16'h7968;
            5'd2:    return 16'h0022;
            5'd3:    return 16'h1550;
            5'd4:    return 16'h01E1;
            5'd5:    return 16'hCDE1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] mirror_link(input logic [REG_W-1:0] stat,
                                                      input logic up);
        logic [REG_W-1:0] r;
        r = stat;
        r[STAT_LINK]    = up;
        r[STAT_AN_DONE] = up;
        return r;
    endfunction

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int OWN_PHY = 1
) (
    input  logic [ADDR_W-1:0]    addr_q,
    output logic                 phy_hit,
    output logic [REG_IDX_W-1:0] reg_idx
);
    localparam int PHY_MSB = PHY_LSB + PHY_IDX_W - 1;

    logic [PHY_IDX_W-1:0] phy_field;
    logic                 unused_addr_bits;

    assign phy_field        = addr_q[PHY_MSB:PHY_LSB];
    assign reg_idx          = addr_q[REG_IDX_W-1:0];
    assign phy_hit          = (phy_field == PHY_IDX_W'(OWN_PHY));
    assign unused_addr_bits = ^{addr_q[ADDR_W-1:PHY_MSB+1], addr_q[PHY_LSB-1:REG_IDX_W]};
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0]     wr_val,
    input  logic [REG_IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0]     rd_word,
    input  logic                 link_up
);
    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] regs;
        logic                           link;
        logic                           sync;
    } rf_t;

    function automatic rf_t initial_state();
        rf_t s;
        for (int i = 0; i < NUM_REGS; i++) begin
            s.regs[i] = power_on_value(REG_IDX_W'(i));
        end
        s.link = 1'b0;
        s.sync = 1'b1;
        return s;
    endfunction

    localparam rf_t RF_INIT = initial_state();

    rf_t rf_d, rf_q;
    logic [REG_W-1:0] val;

    always_comb begin
        rf_d = rf_q;
        val  = wr_val;
        if (wr_en) begin
            if (wr_idx == IDX_CTRL) begin
                if (val[CTRL_SOFT_RST]) begin
                    for (int i = 0; i < NUM_REGS; i++) begin
                        rf_d.regs[i] = power_on_value(REG_IDX_W'(i));
                    end
                    rf_d.regs[IDX_STAT] = mirror_link(rf_d.regs[IDX_STAT], link_up);
                    val[CTRL_SOFT_RST]  = 1'b0;
                end
                if (val[CTRL_AN_REQ]) begin
                    val[CTRL_AN_REQ] = 1'b0;
                    rf_d.regs[IDX_STAT][STAT_AN_DONE] = 1'b1;
                end
            end
            rf_d.regs[wr_idx] = val;
        end
        if (rf_q.sync || (link_up != rf_q.link)) begin
            rf_d.regs[IDX_STAT] = mirror_link(rf_d.regs[IDX_STAT], link_up);
        end
        rf_d.link = link_up;
        rf_d.sync = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= RF_INIT;
        else        rf_q <= rf_d;
    end

    assign rd_word = rf_q.regs[rd_idx];
endmodule

// File: rtl/phy_mgmt_host.sv
module phy_mgmt_host
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic              data_we,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              phy_hit,
    input  logic [REG_W-1:0]  rd_word,
    output logic [ADDR_W-1:0] addr_q,
    output logic [REG_W-1:0]  rd_data,
    output logic              done
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  rdata;
        logic              done;
    } host_t;

    host_t h_d, h_q;
    logic  rd_req;
    logic  unused_cmd_bits;

    assign rd_req          = cmd_we && cmd_word[0];
    assign unused_cmd_bits = ^cmd_word[CMD_W-1:1];

    always_comb begin
        h_d      = h_q;
        h_d.done = data_we || rd_req;
        if (addr_we) h_d.addr = addr_word;
        if (rd_req)  h_d.rdata = phy_hit ? rd_word : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign addr_q  = h_q.addr;
    assign rd_data = h_q.rdata;
    assign done    = h_q.done;
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int CMD_W   = 8,
    parameter int OWN_PHY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_word,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              link_up,
    output logic [REG_W-1:0]  rd_data,
    output logic              done
);
    logic [ADDR_W-1:0]    addr_q;
    logic                 phy_hit;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [REG_W-1:0]     rd_word;
    logic                 unused_data_bits;

    assign unused_data_bits = ^data_word[DATA_W-1:REG_W];

    phy_mgmt_host #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_host (
        .clk(clk), .rst_n(rst_n),
        .addr_we(addr_we), .addr_word(addr_word),
        .data_we(data_we), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .phy_hit(phy_hit), .rd_word(rd_word),
        .addr_q(addr_q), .rd_data(rd_data), .done(done)
    );

    phy_mgmt_decode #(.ADDR_W(ADDR_W), .OWN_PHY(OWN_PHY)) u_decode (
        .addr_q(addr_q), .phy_hit(phy_hit), .reg_idx(reg_idx)
    );

    phy_mgmt_regfile u_regfile (
        .clk(clk), .rst_n(rst_n),
        .wr_en(data_we && phy_hit), .wr_idx(reg_idx),
        .wr_val(data_word[REG_W-1:0]),
        .rd_idx(reg_idx), .rd_word(rd_word),
        .link_up(link_up)
    );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        data_we,
    input logic        cmd_we,
    input logic        cmd_rd,
    input logic        phy_hit,
    input logic [15:0] rd_word,
    input logic [15:0] rd_data,
    input logic        done
);
    p_done_after_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we || (cmd_we && cmd_rd)) |=> done);

    p_done_only_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_we || (cmd_we && cmd_rd)) |=> !done);

    p_foreign_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_rd && !phy_hit) |=> (rd_data == 16'hFFFF));

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_rd && phy_hit) |=> (rd_data == $past(rd_word)));

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && cmd_rd) |=> $stable(rd_data));
endmodule

bind phy_mgmt_responder phy_mgmt_checker u_checker (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .cmd_we(cmd_we),
    .cmd_rd(cmd_word[0]), .phy_hit(phy_hit), .rd_word(rd_word),
    .rd_data(rd_data), .done(done)
);

// File: tb/test_phy_mgmt_responder.sv
`timescale 1ns/1ps
module test_phy_mgmt_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_we = 1'b0;
    logic [15:0] addr_word = '0;
    logic        data_we = 1'b0;
    logic [31:0] data_word = '0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_word = '0;
    logic        link_up = 1'b1;
    logic [15:0] rd_data;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [15:0] m [32];
    int cur_phy = 0;
    int cur_reg = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    phy_mgmt_responder i_phy_mgmt_responder (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_word(addr_word),
        .data_we(data_we), .data_word(data_word), .cmd_we(cmd_we),
        .cmd_word(cmd_word), .link_up(link_up), .rd_data(rd_data), .done(done)
    );

    function automatic logic [15:0] rst_val(int i);
        case (i)
            0: return 16'h1140;
            1: return 16'h7968;
            2: return 16'h0022;
            3: return 16'h1550;
            4: return 16'h01E1;
            5: return 16'hCDE1;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] with_link(logic [15:0] s, logic up);
        logic [15:0] r = s;
        r[2] = up;
        r[5] = up;
        return r;
    endfunction

    task automatic model_reset(logic up);
        for (int i = 0; i < 32; i++) m[i] = rst_val(i);
        m[1] = with_link(m[1], up);
    endtask

    task automatic model_write(logic [15:0] v);
        if (cur_phy != 1) return;
        if (cur_reg == 0) begin
            if (v[15]) begin
                model_reset(link_up);
                v[15] = 1'b0;
            end
            if (v[12]) begin
                v[12] = 1'b0;
                m[1][5] = 1'b1;
            end
        end
        m[cur_reg] = v;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_addr(int phy, int rg);
        addr_we = 1'b1;
        addr_word = {3'b101, 5'(phy), 3'b110, 5'(rg)};
        @(negedge clk);
        addr_we = 1'b0;
        cur_phy = phy;
        cur_reg = rg;
    endtask

    task automatic do_write(logic [31:0] w, string req);
        data_we = 1'b1;
        data_word = w;
        @(negedge clk);
        data_we = 1'b0;
        check("R6", 32'(done), 32'd1, "done after write");
        model_write(w[15:0]);
        check(req, 32'(done), 32'd1, "write accepted");
    endtask

    task automatic do_read(string req);
        logic [15:0] exp;
        cmd_we = 1'b1;
        cmd_word = 8'h01 | 8'($urandom_range(0, 255) & 8'hFE);
        @(negedge clk);
        cmd_we = 1'b0;
        exp = (cur_phy == 1) ? m[cur_reg] : 16'hFFFF;
        check(req, 32'(rd_data), 32'(exp), "read data");
        check("R6", 32'(done), 32'd1, "done after read");
        last_rd = exp;
    endtask

    task automatic read_reg(int phy, int rg, string req);
        set_addr(phy, rg);
        do_read(req);
    endtask

    task automatic set_link(logic up);
        link_up = up;
        @(negedge clk);
        m[1] = with_link(m[1], up);
        check("R6", 32'(done), 32'd0, "done idle");
    endtask

    task automatic hw_reset(logic up);
        link_up = up;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_reset(up);
        last_rd = '0;
        check("R2", 32'(rd_data), 32'd0, "rd_data after reset");
        check("R6", 32'(done), 32'd0, "done after reset");
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        hw_reset(1'b1);

        // R2 / R9: reset values with link up
        for (int i = 0; i < 8; i++) read_reg(1, i, "R2");
        read_reg(1, 1, "R9");
        check("R9", 32'(m[1]), 32'h796C, "status with link up");
        read_reg(1, 31, "R2");

        // R3: foreign reads
        read_reg(0, 0, "R3");
        read_reg(2, 1, "R3");
        read_reg(31, 2, "R3");

        // R5: command with bit 0 clear leaves rd_data
        cmd_we = 1'b1;
        cmd_word = 8'hFE;
        @(negedge clk);
        cmd_we = 1'b0;
        check("R5", 32'(rd_data), 32'(last_rd), "rd_data hold on no-read command");
        check("R6", 32'(done), 32'd0, "no done on no-read command");

        // R1 / R5: write then read, upper data bits dropped
        set_addr(1, 9);
        do_write(32'hABCD_5A3C, "R5");
        do_read("R1");
        check("R5", 32'(rd_data), 32'h5A3C, "low half stored");

        // R4: foreign write ignored
        set_addr(3, 9);
        do_write(32'h0000_FFFF, "R4");
        read_reg(1, 9, "R4");
        check("R4", 32'(rd_data), 32'h5A3C, "register untouched");

        // R8: autonegotiation request
        set_link(1'b0);
        read_reg(1, 1, "R9");
        check("R9", 32'(rd_data), 32'h7948, "status with link down");
        set_addr(1, 0);
        do_write(32'h0000_1100, "R8");
        read_reg(1, 0, "R8");
        check("R8", 32'(rd_data), 32'h0100, "request bit self-cleared");
        read_reg(1, 1, "R8");
        check("R8", 32'(rd_data), 32'h7968, "an-complete set");

        // R7: soft reset
        set_addr(1, 4);
        do_write(32'h0000_1234, "R5");
        set_addr(1, 0);
        do_write(32'h0000_8000, "R7");
        read_reg(1, 0, "R7");
        check("R7", 32'(rd_data), 32'h0000, "reset bit cleared, value stored");
        read_reg(1, 4, "R7");
        check("R7", 32'(rd_data), 32'h01E1, "reload");
        read_reg(1, 1, "R9");
        check("R9", 32'(rd_data), 32'h7948, "link applied at soft reset");
        set_link(1'b1);
        read_reg(1, 1, "R9");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) begin
                set_addr(($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : 1,
                         $urandom_range(0, 7) == 0 ? $urandom_range(0, 31) : $urandom_range(0, 5));
            end else if (op < 6) begin
                do_write($urandom(), "R5");
            end else if (op < 9) begin
                do_read("R5");
            end else begin
                set_link(~link_up);
            end
        end

        // R2 / R9: hardware reset with link down
        hw_reset(1'b0);
        read_reg(1, 1, "R9");
        check("R9", 32'(rd_data), 32'h7948, "status after reset, link down");
        read_reg(1, 0, "R2");
        read_reg(1, 9, "R2");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule